// File: doc/BRIEF.md
# Walking-Pattern Data Line Tester

This block is a hardware self-test engine for a 32-bit memory bus. It looks for data lines that are shorted together or left open. A start pulse loads a byte start address and a region length. The engine then covers the region in fixed-size chunks.

For each chunk it first writes a full set of walking-bit words. Each bit position gets a pair of words: the inverted one-hot word, then the one-hot word itself. After all the writes it reads every word back. Any bit that differs from the value written is ORed into a 32-bit fault mask.

The engine stops at the first chunk whose mask is non-zero and reports that chunk's base address. If every chunk is clean, it reports a pass with a zero mask and the base of the last chunk it tested. All traffic goes through a single word-wide request port. A request is held until it is granted, and read data returns later on a valid strobe.

Top module: `dline_walker`

## Requirements
- R1: In a chunk whose base is B, word j lives at byte address B+4j, for j from 0 to 63. For bit k (0..31), word 2k holds ~(1<<k) and word 2k+1 holds (1<<k). Every address is word aligned, so bits [1:0] are 0.
- R2: All 64 writes of a chunk are granted before the first read of that chunk is requested.
- R3: Each read word is XORed with the value written to that word, and the result is ORed into the fault mask. Both the inverted words and the one-hot words count. The mask is cleared at the start of every chunk.
- R4: If a chunk ends with a non-zero mask, the engine stops without touching another chunk. It raises done with pass=0, shows the mask on fault_mask, and shows the chunk base on chunk_addr.
- R5: If a chunk is clean, the base advances by CHUNK_BYTES. Testing continues while the new base is below start_addr+region_bytes, with the sum computed without wrap-around. At least one chunk is always tested, even when region_bytes is 0.
- R6: After a clean run, done=1, pass=1, fault_mask=0, and chunk_addr is the base of the last chunk tested.
- R7: Memory port rules:
  - A request holds mem_we, mem_addr and mem_wdata steady until a cycle in which mem_gnt is high.
  - After a read is granted, the engine requests nothing more until mem_rvalid returns that read's data.
- R8: A start pulse is ignored while a test is running. done stays high until the next start, and falls in the cycle after that start is accepted.
- R9: After reset, done, pass and mem_req are 0, and fault_mask and chunk_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle start pulse |
| start_addr | input | 32 | Byte address of the first chunk |
| region_bytes | input | 32 | Length of the region in bytes |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| done | output | 1 | Test finished; held until next start |
| pass | output | 1 | No fault found (valid while done) |
| fault_mask | output | 32 | Data bits found faulty |
| chunk_addr | output | 32 | Failing chunk base, or last chunk base on pass |

## Verification
Several rules are checked every cycle by assertions:
- the port handshake: held requests, a single outstanding read, and aligned addresses;
- the write-before-read order inside a chunk;
- the mask only gaining bits inside a chunk;
- the base stepping by one chunk;
- done staying high and agreeing with pass and the mask.

Some behaviour only the directed scenarios can show, because they use a bench memory that injects stuck bits into a chosen chunk:
- the exact walking words that reach memory;
- which bits a given fault sets in the mask;
- where the engine stops;
- how many chunks a region of a given length covers.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  localparam int DATA_W = 32;
  localparam int WORDS  = 2 * DATA_W;
  localparam int IDX_W  = $clog2(WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RREQ,
    ST_RWAIT,
    ST_EVAL,
    ST_DONE
  } dlw_state_e;

  // Value written to word index idx of a chunk: even = inverted one-hot, odd = one-hot.
  function automatic logic [DATA_W-1:0] walk_word(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] onehot;
    onehot = {{(DATA_W-1){1'b0}}, 1'b1} << idx[IDX_W-1:1];
    return idx[0] ? onehot : ~onehot;
  endfunction

  // Bits of a read word that disagree with what was written.
  function automatic logic [DATA_W-1:0] miss_bits(input logic [DATA_W-1:0] got,
                                                  input logic [IDX_W-1:0]  idx);
    return got ^ walk_word(idx);
  endfunction

endpackage

// File: rtl/dlw_accum.sv
module dlw_accum
  import dlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mask,
  output logic              mask_nz
);

  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else if (acc_en) begin
      mask_q <= mask_q | miss_bits(rdata, idx);
    end
  end

  assign mask    = mask_q;
  assign mask_nz = |mask_q;

  // R3: inside a chunk the mask never loses a bit
  a_r3_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !clr) |=> ((mask_q | $past(mask_q)) == mask_q));

  // R3: a chunk starts from an empty mask
  a_r3_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask_q == '0));

endmodule

// File: rtl/dlw_seq.sv
module dlw_seq
  import dlw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] region_bytes,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic              mask_nz,
  output dlw_state_e        state,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base,
  output logic              ev_start,
  output logic              ev_wr_acc,
  output logic              ev_rd_data,
  output logic              chunk_clr,
  output logic              done,
  output logic              pass
);

  localparam logic [ADDR_W:0]    STEP     = (ADDR_W+1)'(CHUNK_BYTES);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(WORDS - 1);

  dlw_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W:0]   limit_q, limit_d;
  logic              done_q, done_d, pass_q, pass_d;
  logic [ADDR_W:0]   next_base;
  logic              more, last_word, ev_rd_acc, advance;

  assign next_base  = {1'b0, base_q} + STEP;
  assign more       = next_base < limit_q;
  assign last_word  = (idx_q == LAST_IDX);
  assign ev_start   = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign ev_wr_acc  = (state_q == ST_WRITE) && mem_gnt;
  assign ev_rd_acc  = (state_q == ST_RREQ) && mem_gnt;
  assign ev_rd_data = (state_q == ST_RWAIT) && mem_rvalid;
  assign advance    = (state_q == ST_EVAL) && !mask_nz && more;
  assign chunk_clr  = ev_start || advance;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    base_d  = base_q;
    limit_d = limit_q;
    done_d  = done_q;
    pass_d  = pass_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (ev_start) begin
          state_d = ST_WRITE;
          idx_d   = '0;
          base_d  = start_addr;
          limit_d = {1'b0, start_addr} + {1'b0, region_bytes};
          done_d  = 1'b0;
          pass_d  = 1'b0;
        end
      end
      ST_WRITE: begin
        if (ev_wr_acc) begin
          if (last_word) begin
            idx_d   = '0;
            state_d = ST_RREQ;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_RREQ: begin
        if (ev_rd_acc) state_d = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (ev_rd_data) begin
          if (last_word) begin
            idx_d   = '0;
            state_d = ST_EVAL;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_RREQ;
          end
        end
      end
      ST_EVAL: begin
        if (mask_nz) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          pass_d  = 1'b0;
        end else if (more) begin
          base_d  = next_base[ADDR_W-1:0];
          state_d = ST_WRITE;
        end else begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          pass_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      limit_q <= limit_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
    end
  end

  assign state = state_q;
  assign idx   = idx_q;
  assign base  = base_q;
  assign done  = done_q;
  assign pass  = pass_q;

  // R4: a faulty chunk ends the run as a failure
  a_r4_stop_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL && mask_nz) |=> (done_q && !pass_q && state_q == ST_DONE));

  // R5: a new chunk begins exactly one chunk above the previous one
  a_r5_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL && !mask_nz && more) |=>
      ({1'b0, base_q} == {1'b0, $past(base_q)} + STEP));

  // R8: done is held until a start is accepted
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> done_q);

  // R8: an accepted start drops done
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !done_q);

  // R8: a start while running leaves the region untouched
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != ST_IDLE && state_q != ST_DONE) |=> $stable(limit_q));

endmodule

// File: rtl/dlw_port.sv
module dlw_port
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  dlw_state_e        state,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  assign mem_req   = (state == ST_WRITE) || (state == ST_RREQ);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = base + ADDR_W'({idx, 2'b00});
  assign mem_wdata = walk_word(idx);

endmodule

// File: rtl/dline_walker.sv
module dline_walker
  import dlw_pkg::*;
#(
  parameter int CHUNK_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic [31:0] region_bytes,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rvalid,
  output logic        done,
  output logic        pass,
  output logic [31:0] fault_mask,
  output logic [31:0] chunk_addr
);

  localparam int ADDR_W = 32;
  localparam int BEAT_W = IDX_W + 1;

  dlw_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  logic              ev_start, ev_wr_acc, ev_rd_data, chunk_clr, mask_nz;

  dlw_seq #(.ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .region_bytes(region_bytes), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mask_nz(mask_nz), .state(state), .idx(idx), .base(base),
    .ev_start(ev_start), .ev_wr_acc(ev_wr_acc), .ev_rd_data(ev_rd_data),
    .chunk_clr(chunk_clr), .done(done), .pass(pass)
  );

  dlw_accum u_acc (
    .clk(clk), .rst_n(rst_n), .clr(chunk_clr), .acc_en(ev_rd_data),
    .idx(idx), .rdata(mem_rdata), .mask(fault_mask), .mask_nz(mask_nz)
  );

  dlw_port #(.ADDR_W(ADDR_W)) u_port (
    .state(state), .idx(idx), .base(base), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign chunk_addr = base;

  // Independent count of granted writes in the current chunk, used by the checks.
  logic [BEAT_W-1:0] wr_beats;
  logic              rd_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_beats <= '0;
      rd_open  <= 1'b0;
    end else begin
      if (chunk_clr)      wr_beats <= '0;
      else if (ev_wr_acc) wr_beats <= wr_beats + 1'b1;
      if (mem_req && !mem_we && mem_gnt) rd_open <= 1'b1;
      else if (mem_rvalid)               rd_open <= 1'b0;
    end
  end

  // R2: reads of a chunk only after all of its writes
  a_r2_write_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (wr_beats == BEAT_W'(WORDS)));

  // R1: word-aligned addresses
  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R7: an ungranted request stays put
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R7: one read outstanding at a time
  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_req);

  // R6: a pass always carries a clean mask
  a_r6_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (fault_mask == '0));

  // R4: a failure always carries a mask
  a_r4_fail_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> (fault_mask != '0));

endmodule

// File: tb/tb_dline_walker.sv
`timescale 1ns/1ps
module tb_dline_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0, region_bytes = '0;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, pass;
  logic [31:0] fault_mask, chunk_addr;

  always #5 clk = ~clk;

  dline_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .region_bytes(region_bytes), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .done(done), .pass(pass),
    .fault_mask(fault_mask), .chunk_addr(chunk_addr)
  );

  int n_checks = 0, n_fail = 0;

  // fault injection setup (read path only)
  logic        flt_en = 1'b0, flt_odd = 1'b0;
  logic [31:0] flt_base = '0, flt_s0 = '0, flt_s1 = '0;
  int          run_wr0 = 0;
  logic [31:0] run_start = '0;

  function automatic logic [31:0] corrupt(input logic [31:0] d, input logic [31:0] a);
    if (flt_en && a[31:8] == flt_base[31:8] && (!flt_odd || a[2]))
      return (d & ~flt_s0) | flt_s1;
    return d;
  endfunction

  // memory model
  logic [31:0] mem [0:1023];
  logic [3:0]  lfsr;
  logic [1:0]  latc, rd_lat;
  logic        rd_busy, req_p, gnt_p, we_p;
  logic [31:0] addr_p, wd_p, rd_hold;
  int          wr_cnt, viol;
  assign mem_gnt = mem_req && (lfsr[0] | lfsr[2]);

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 4'h9; latc <= 2'd0; rd_busy <= 1'b0; mem_rvalid <= 1'b0;
      mem_rdata <= '0; wr_cnt <= 0; viol <= 0; req_p <= 1'b0; gnt_p <= 1'b0;
      rd_lat <= '0; rd_hold <= '0; we_p <= 1'b0; addr_p <= '0; wd_p <= '0;
    end else begin
      lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      req_p <= mem_req; gnt_p <= mem_gnt; we_p <= mem_we;
      addr_p <= mem_addr; wd_p <= mem_wdata;
      if (req_p && !gnt_p && (!mem_req || mem_we != we_p || mem_addr != addr_p || mem_wdata != wd_p))
        viol <= viol + 1;
      if (mem_req && (rd_busy || mem_rvalid)) viol <= viol + 1;
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          if ((wr_cnt - run_wr0) < 64 * (((mem_addr - run_start) >> 8) + 1)) viol <= viol + 1;
          rd_hold <= corrupt(mem[mem_addr[11:2]], mem_addr);
          rd_lat  <= latc;
          latc    <= (latc == 2'd2) ? 2'd0 : latc + 2'd1;
          rd_busy <= 1'b1;
        end
      end else if (rd_busy) begin
        if (rd_lat == 0) begin
          mem_rvalid <= 1'b1; mem_rdata <= rd_hold; rd_busy <= 1'b0;
        end else rd_lat <= rd_lat - 2'd1;
      end
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // expected mask of one chunk, restated from R1/R3
  function automatic logic [31:0] exp_mask(input logic [31:0] b);
    logic [31:0] m = '0;
    for (int j = 0; j < 64; j++) begin
      logic [31:0] w;
      w = (j % 2 == 1) ? (32'h1 << (j / 2)) : ~(32'h1 << (j / 2));
      m |= corrupt(w, b + 32'(4 * j)) ^ w;
    end
    return m;
  endfunction

  task automatic pulse_start(input logic [31:0] sa, input logic [31:0] sz);
    @(negedge clk);
    start_addr = sa; region_bytes = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin n_checks++; n_fail++; $display("FAIL R8: actual timeout expected done"); end
  endtask

  // full run with expected result derived from R4/R5/R6
  task automatic run_and_check(input string rq, input logic [31:0] sa, input logic [31:0] sz);
    logic [31:0] b, m;
    longint lim;
    int chunks;
    bit ok;
    b = sa; lim = longint'(sa) + longint'(sz); chunks = 0;
    forever begin
      chunks++;
      m = exp_mask(b);
      if (m != 0) break;
      if (longint'(b) + 256 < lim) b = b + 32'd256; else break;
    end
    run_wr0 = wr_cnt; run_start = sa;
    pulse_start(sa, sz);
    check({rq, " R8 done drops"}, {31'b0, done}, 32'd0);
    wait_done(ok);
    if (!ok) return;
    check({rq, " pass"}, {31'b0, pass}, {31'b0, (m == 0)});
    check({rq, " mask"}, fault_mask, m);
    check({rq, " chunk_addr"}, chunk_addr, b);
    check({rq, " R5 write count"}, 32'(wr_cnt - run_wr0), 32'(64 * chunks));
    check({rq, " R7/R2 protocol"}, 32'(viol), 32'd0);
  endtask

  task automatic t_reset();
    check("R9 done", {31'b0, done}, 32'd0);
    check("R9 pass", {31'b0, pass}, 32'd0);
    check("R9 req", {31'b0, mem_req}, 32'd0);
    check("R9 mask", fault_mask, 32'd0);
    check("R9 addr", chunk_addr, 32'd0);
  endtask

  task automatic t_clean_multi();
    flt_en = 1'b0;
    run_and_check("R6 clean 3 chunks", 32'h100, 32'h300);
    check("R6 last base", chunk_addr, 32'h300);
    for (int k = 0; k < 32; k += 5) begin
      check("R1 inverted word", mem[(32'h300 >> 2) + 2 * k], ~(32'h1 << k));
      check("R1 true word", mem[(32'h300 >> 2) + 2 * k + 1], 32'h1 << k);
    end
  endtask

  task automatic t_partial_and_zero();
    flt_en = 1'b0;
    run_and_check("R5 partial region", 32'h0, 32'h180);
    check("R5 partial last base", chunk_addr, 32'h100);
    run_and_check("R5 zero length", 32'h400, 32'h0);
    check("R5 zero length base", chunk_addr, 32'h400);
  endtask

  task automatic t_stuck_high();
    flt_en = 1'b1; flt_odd = 1'b0; flt_base = 32'h200; flt_s0 = '0; flt_s1 = 32'h80;
    run_and_check("R4 stuck-high", 32'h0, 32'h400);
    check("R4 fail base", chunk_addr, 32'h200);
    check("R4 mask bit7", fault_mask, 32'h80);
  endtask

  task automatic t_true_word_only();
    flt_en = 1'b1; flt_odd = 1'b1; flt_base = 32'h100; flt_s0 = '0; flt_s1 = 32'h8;
    run_and_check("R3 true words only", 32'h0, 32'h300);
    check("R3 mask bit3", fault_mask, 32'h8);
  endtask

  task automatic t_stuck_low_edges();
    flt_en = 1'b1; flt_odd = 1'b0; flt_base = 32'h0; flt_s0 = 32'h8000_0001; flt_s1 = '0;
    run_and_check("R4 stuck-low edge bits", 32'h0, 32'h200);
    check("R4 edge mask", fault_mask, 32'h8000_0001);
    flt_en = 1'b0;
    run_and_check("R3 mask cleared for new run", 32'h0, 32'h100);
    check("R3 clean after fail", fault_mask, 32'h0);
  endtask

  task automatic t_busy_start();
    bit ok;
    flt_en = 1'b0;
    run_wr0 = wr_cnt; run_start = 32'h0;
    pulse_start(32'h0, 32'h200);
    repeat (6) @(negedge clk);
    start_addr = 32'h800; region_bytes = 32'h0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    start_addr = 32'h0; region_bytes = 32'h200;
    wait_done(ok);
    if (!ok) return;
    check("R8 busy start ignored addr", chunk_addr, 32'h100);
    check("R8 busy start ignored writes", 32'(wr_cnt - run_wr0), 32'd128);
    repeat (20) @(negedge clk);
    check("R8 done held", {31'b0, done}, 32'd1);
    check("R8 pass held", {31'b0, pass}, 32'd1);
  endtask

  int cyc = 0;
  bit timed_out = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !timed_out) timed_out <= 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_clean_multi();
        t_partial_and_zero();
        t_stuck_high();
        t_true_word_only();
        t_stuck_low_edges();
        t_busy_start();
      end
      begin
        wait (timed_out);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule